// File: doc/BRIEF.md
# Gray-Order Quadratic Evaluator Chain over GF(2)

This block tracks the values of several quadratic polynomials over GF(2) while an external enumerator walks the input space in Gray-code order. It never evaluates a polynomial directly. Each equation keeps a constant table of pairwise second derivatives. Each of its instances keeps a small writable store of first derivatives and a one-bit running value. On every step exactly one input variable flips. The instance then corrects the first derivative of that variable with at most one table bit and folds the result into its running value.

The instances of one equation share the table and the step address. They differ only in the values of a few high variables that are held fixed per instance, and those values are folded into the initial first derivatives and running value. The equations form a pipeline: every stage registers the step bus and passes on a per-instance flag. The flag is the OR of the running values seen so far, so a final flag of 0 marks an input that satisfies every equation in the chain. A load port writes the initial tables, first derivatives and running values before the walk begins.

Top module: `gf2_quad_chain`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sol_valid` is 0 and `sol` is all zeros. Reset also clears every table bit, every first derivative and every running value.
- R2: On a step with `in_en`=1 and flip index k, each instance replaces its first derivative for variable k with that value XOR the table bit at `in_addr`. When `in_k2ok`=0 the table bit is treated as 0. The table index for a flip at k with previous change at j (j>k) is j*(j-1)/2+k.
- R3: On the same step, each instance XORs its running value with the updated first derivative (not the old one).
- R4: Each equation stage forms its outgoing flag per instance as the incoming flag OR its own updated running value, with the incoming flag of the first stage fixed at 0. After step number c from a loaded start, bit i of `sol` equals the OR over all equations of that equation's value at x = c XOR (c>>1) with instance i's fixed high variables applied.
- R5: The result of a step presented on the input is visible on `sol`/`sol_valid` after NEQ+1 rising edges, counting the one that captures it. Steps are accepted back to back, one per cycle.
- R6: A cycle with `in_en`=0 changes no state. It yields `sol_valid`=0 NEQ+1 edges later, and `sol` keeps its last value.
- R7: With `ld_en`=1 and `in_en`=0, `ld_sel` selects the target in equation `ld_eq`: 0 writes `ld_bit` into the running value of instance `ld_inst`, 1 writes it into that instance's first derivative at index `ld_idx`, and 2 writes it into the shared table entry `ld_idx` (`ld_inst` is ignored).
- R8: The four instances of an equation all use the same table bit on each step, and each gives its own result from its own loaded first derivatives and running value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Step present this cycle |
| in_k1 | input | K_W | Index of the variable that flips |
| in_k2ok | input | 1 | Table address is meaningful |
| in_addr | input | A_W | Second-derivative table index |
| ld_en | input | 1 | Load write strobe |
| ld_sel | input | 2 | Load target: 0 running value, 1 first derivative, 2 table |
| ld_eq | input | EQ_W | Equation selected for the load |
| ld_inst | input | INST_W | Instance selected for the load |
| ld_idx | input | IDX_W | Derivative index or table index |
| ld_bit | input | 1 | Bit to write |
| sol_valid | output | 1 | `sol` carries the result of a step |
| sol | output | NINST | Per-instance chained flag; 0 means all equations satisfied |

## Verification
A step handed in ahead of a capture edge reaches `sol` after NEQ+1 rising edges. For the default two equations that is three edges, and the bench samples on the falling edge that follows the third. The bench stamps each issued step with its due cycle and keeps a queue of expected flags computed by direct polynomial evaluation. On every cycle it compares the output against the head of that queue when the head is due. On any other cycle it expects `sol_valid` low and `sol` unchanged, so a step that arrives early, arrives late or goes missing fails at once. Idle cycles mixed into the walk check that a gap shifts no later result.

// File: rtl/gf2_quad_pkg.sv
package gf2_quad_pkg;

    localparam int MAX_K_W = 6;   // up to 64 variables
    localparam int MAX_A_W = 11;  // up to 2016 pairs

    typedef enum logic [1:0] {
        LK_Y  = 2'd0,
        LK_D1 = 2'd1,
        LK_D2 = 2'd2,
        LK_NONE = 2'd3
    } load_kind_e;

    typedef struct packed {
        logic               en;
        logic               k2ok;
        logic [MAX_K_W-1:0] k1;
        logic [MAX_A_W-1:0] addr;
    } step_t;

    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gf2_quad_inst.sv
module gf2_quad_inst #(
    parameter int NVARS = 8,
    parameter int K_W   = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step_en,
    input  logic [K_W-1:0] k1,
    input  logic           k2ok,
    input  logic           d2bit,
    input  logic           wr_y,
    input  logic           wr_d1,
    input  logic [K_W-1:0] wr_idx,
    input  logic           wr_bit,
    output logic           y_next
);
    logic d1 [NVARS];
    logic y;
    logic d1_new;

    always_comb begin
        d1_new = d1[k1] ^ (k2ok & d2bit);
        y_next = y ^ d1_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y  <= 1'b0;
            d1 <= '{default: 1'b0};
        end else if (step_en) begin
            d1[k1] <= d1_new;
            y      <= y_next;
        end else begin
            if (wr_d1) d1[wr_idx] <= wr_bit;
            if (wr_y)  y          <= wr_bit;
        end
    end
endmodule

// File: rtl/gf2_quad_stage.sv
module gf2_quad_stage
    import gf2_quad_pkg::*;
#(
    parameter int NVARS  = 8,
    parameter int NINST  = 4,
    parameter int K_W    = 3,
    parameter int A_W    = 5,
    parameter int IDX_W  = 5,
    parameter int INST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             bus_in,
    input  logic [NINST-1:0]  flag_in,
    input  logic              ld_hit,
    input  load_kind_e        ld_kind,
    input  logic [INST_W-1:0] ld_inst,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic              ld_bit,
    output step_t             bus_out,
    output logic [NINST-1:0]  flag_out,
    output logic              flag_vld
);
    localparam int NPAIR = pair_count(NVARS);

    step_t            bus_q;
    logic             tbl [NPAIR];
    logic             d2bit;
    logic [A_W-1:0]   rd_a;
    logic [NINST-1:0] ynext;
    logic [NINST-1:0] flag_q;
    logic             vld_q;

    always_comb begin
        rd_a  = bus_q.addr[A_W-1:0];
        d2bit = (int'(rd_a) < NPAIR) ? tbl[rd_a] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q  <= '0;
            tbl    <= '{default: 1'b0};
            flag_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            bus_q <= bus_in;
            vld_q <= bus_q.en;
            if (bus_q.en) flag_q <= flag_in | ynext;
            if (!bus_in.en && !bus_q.en && ld_hit && ld_kind == LK_D2
                && int'(ld_idx[A_W-1:0]) < NPAIR)
                tbl[ld_idx[A_W-1:0]] <= ld_bit;
        end
    end

    for (genvar i = 0; i < NINST; i++) begin : g_inst
        logic sel;
        assign sel = ld_hit && (ld_inst == INST_W'(i));
        gf2_quad_inst #(.NVARS(NVARS), .K_W(K_W)) u_inst (
            .clk    (clk),
            .rst    (rst),
            .step_en(bus_q.en),
            .k1     (bus_q.k1[K_W-1:0]),
            .k2ok   (bus_q.k2ok),
            .d2bit  (d2bit),
            .wr_y   (sel && ld_kind == LK_Y),
            .wr_d1  (sel && ld_kind == LK_D1),
            .wr_idx (ld_idx[K_W-1:0]),
            .wr_bit (ld_bit),
            .y_next (ynext[i])
        );
    end

    assign bus_out  = bus_q;
    assign flag_out = flag_q;
    assign flag_vld = vld_q;
endmodule

// File: rtl/gf2_quad_chain.sv
module gf2_quad_chain
    import gf2_quad_pkg::*;
#(
    parameter int NVARS  = 8,
    parameter int NEQ    = 2,
    parameter int NINST  = 4,
    localparam int K_W    = width_of(NVARS),
    localparam int A_W    = width_of(pair_count(NVARS)),
    localparam int IDX_W  = (K_W > A_W) ? K_W : A_W,
    localparam int EQ_W   = width_of(NEQ),
    localparam int INST_W = width_of(NINST)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_en,
    input  logic [K_W-1:0]    in_k1,
    input  logic              in_k2ok,
    input  logic [A_W-1:0]    in_addr,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [EQ_W-1:0]   ld_eq,
    input  logic [INST_W-1:0] ld_inst,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic              ld_bit,
    output logic              sol_valid,
    output logic [NINST-1:0]  sol
);
    step_t            bus  [NEQ+1];
    logic [NINST-1:0] flg  [NEQ+1];
    logic             vld  [NEQ];
    logic [NEQ-1:0]   stg_en;
    load_kind_e       ld_kind;

    always_comb begin
        bus[0]      = '0;
        bus[0].en   = in_en;
        bus[0].k2ok = in_k2ok;
        bus[0].k1   = MAX_K_W'(in_k1);
        bus[0].addr = MAX_A_W'(in_addr);
        flg[0]      = '0;
        ld_kind     = load_kind_e'(ld_sel);
    end

    for (genvar j = 0; j < NEQ; j++) begin : g_eq
        gf2_quad_stage #(
            .NVARS(NVARS), .NINST(NINST), .K_W(K_W), .A_W(A_W),
            .IDX_W(IDX_W), .INST_W(INST_W)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .bus_in  (bus[j]),
            .flag_in (flg[j]),
            .ld_hit  (ld_en && (ld_eq == EQ_W'(j))),
            .ld_kind (ld_kind),
            .ld_inst (ld_inst),
            .ld_idx  (ld_idx),
            .ld_bit  (ld_bit),
            .bus_out (bus[j+1]),
            .flag_out(flg[j+1]),
            .flag_vld(vld[j])
        );
        assign stg_en[j] = bus[j+1].en;
    end

    assign sol       = flg[NEQ];
    assign sol_valid = vld[NEQ-1];
endmodule

// File: rtl/gf2_quad_chain_chk.sv
module gf2_quad_chain_chk #(
    parameter int NEQ   = 2,
    parameter int NINST = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_en,
    input logic [NEQ-1:0]   stg_en,
    input logic             sol_valid,
    input logic [NINST-1:0] sol
);
    // R1: reset clears the output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!sol_valid && sol == '0));

    // R6: no step, no change of the flags
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !sol_valid |-> $stable(sol));

    // R5: first stage captures the input step one edge later
    p_entry_r5: assert property (@(posedge clk) disable iff (rst)
        stg_en[0] == $past(in_en));

    // R5: each stage follows its predecessor by one edge
    for (genvar j = 0; j + 1 < NEQ; j++) begin : g_hop
        p_hop_r5: assert property (@(posedge clk) disable iff (rst)
            stg_en[j+1] == $past(stg_en[j]));
    end

    // R5: output valid trails the last stage by one edge
    p_exit_r5: assert property (@(posedge clk) disable iff (rst)
        sol_valid == $past(stg_en[NEQ-1]));
endmodule

bind gf2_quad_chain gf2_quad_chain_chk #(.NEQ(NEQ), .NINST(NINST)) u_chk (
    .clk(clk), .rst(rst), .in_en(in_en), .stg_en(stg_en),
    .sol_valid(sol_valid), .sol(sol)
);

// File: tb/gf2_quad_chain_test.sv
module gf2_quad_chain_test;
    localparam int NV  = 8;
    localparam int NT  = NV + 2;
    localparam int NEQ = 2;
    localparam int NI  = 4;
    localparam int LAT = NEQ + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_en = 1'b0, in_k2ok = 1'b0;
    logic [2:0] in_k1 = '0;
    logic [4:0] in_addr = '0;
    logic ld_en = 1'b0, ld_bit = 1'b0;
    logic [1:0] ld_sel = '0, ld_inst = '0;
    logic [0:0] ld_eq = '0;
    logic [4:0] ld_idx = '0;
    logic sol_valid;
    logic [NI-1:0] sol;

    always #4 clk = ~clk;

    gf2_quad_chain uut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_k1(in_k1), .in_k2ok(in_k2ok),
        .in_addr(in_addr), .ld_en(ld_en), .ld_sel(ld_sel), .ld_eq(ld_eq),
        .ld_inst(ld_inst), .ld_idx(ld_idx), .ld_bit(ld_bit),
        .sol_valid(sol_valid), .sol(sol)
    );

    int total = 0, bad = 0, cyc = 0;
    bit pq  [NEQ][NT][NT];
    bit lin [NEQ][NT];
    bit cst [NEQ];
    int due_q [$];
    logic [NI-1:0] exp_q [$];
    logic [NI-1:0] last_sol = '0;

    function automatic bit evalf(int e, int x);
        bit r = cst[e];
        for (int a = 0; a < NT; a++) begin
            if (lin[e][a] && x[a]) r ^= 1'b1;
            for (int b = 0; b < a; b++)
                if (pq[e][a][b] && x[a] && x[b]) r ^= 1'b1;
        end
        return r;
    endfunction

    function automatic logic [NI-1:0] expect_at(int c);
        logic [NI-1:0] f = '0;
        int g = c ^ (c >> 1);
        for (int i = 0; i < NI; i++)
            for (int e = 0; e < NEQ; e++)
                f[i] |= evalf(e, g | (i << NV));
        return f;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, expv);
        end
    endtask

    task automatic observe();
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            void'(due_q.pop_front());
            last_sol = exp_q.pop_front();
            // R2 R3 R4 R8: flags against direct evaluation
            chk(sol_valid === 1'b1, "R5 valid on due cycle", int'(sol_valid), 1);
            chk(sol === last_sol, "R2 R3 R4 R8 flags", int'(sol), int'(last_sol));
        end else begin
            // R6: off-cycle output low and held
            chk(sol_valid === 1'b0, "R5 R6 no result expected", int'(sol_valid), 0);
            chk(sol === last_sol, "R6 flags held", int'(sol), int'(last_sol));
        end
    endtask

    task automatic tick(bit en, int k1, bit k2ok, int addr, bit le, int sel,
                        int eq, int inst, int idx, bit b, int c);
        @(negedge clk);
        cyc++;
        if (!rst) observe();
        in_en = en; in_k1 = 3'(k1); in_k2ok = k2ok; in_addr = 5'(addr);
        ld_en = le; ld_sel = 2'(sel); ld_eq = 1'(eq); ld_inst = 2'(inst);
        ld_idx = 5'(idx); ld_bit = b;
        if (en) begin
            due_q.push_back(cyc + LAT);
            exp_q.push_back(expect_at(c));
        end
    endtask

    task automatic load(int sel, int eq, int inst, int idx, bit b);
        tick(0, 0, 0, 0, 1, sel, eq, inst, idx, b, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        due_q.delete(); exp_q.delete(); last_sol = '0;
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        // R1: held in reset
        chk(sol_valid === 1'b0 && sol === '0, "R1 reset state", int'({sol_valid, sol}), 0);
        rst = 1'b0;
    endtask

    // R7: load folded initial state through the write port
    task automatic load_all();
        for (int e = 0; e < NEQ; e++) begin
            for (int k = 1; k < NV; k++)
                for (int j = 0; j < k; j++)
                    load(2, e, 0, k * (k - 1) / 2 + j, pq[e][k][j]);
            for (int i = 0; i < NI; i++) begin
                bit h0 = i[0], h1 = i[1];
                bit lp [NV];
                for (int k = 0; k < NV; k++)
                    lp[k] = lin[e][k] ^ (pq[e][NV][k] & h0) ^ (pq[e][NV+1][k] & h1);
                load(0, e, i, 0, evalf(e, i << NV));
                load(1, e, i, 0, lp[0]);
                for (int k = 1; k < NV; k++)
                    load(1, e, i, k, pq[e][k][k-1] ^ lp[k]);
            end
        end
    endtask

    task automatic walk(int gap);
        for (int c = 1; c < (1 << NV); c++) begin
            int k1 = 0, k2 = 0;
            bit ok;
            while (!c[k1]) k1++;
            k2 = k1 + 1;
            while (k2 < NV && !c[k2]) k2++;
            ok = (k2 < NV);
            if (gap > 0 && c % gap == 0)
                tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // R6 idle gap
            tick(1, k1, ok, ok ? k2 * (k2 - 1) / 2 + k1 : 0, 0, 0, 0, 0, 0, 0, c);
        end
        for (int d = 0; d < LAT + 2; d++)
            tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic set_poly(int mode);
        for (int e = 0; e < NEQ; e++) begin
            cst[e] = (mode == 1) ? 1'b1 : (mode == 0 ? 1'b0 : 1'($urandom));
            for (int a = 0; a < NT; a++) begin
                lin[e][a] = (mode >= 2) ? 1'($urandom) : 1'b0;
                for (int b = 0; b < NT; b++)
                    pq[e][a][b] = (mode >= 2 && b < a) ? 1'($urandom) : 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(7));
        // random systems, back to back and with idle gaps
        for (int p = 0; p < 3; p++) begin
            set_poly(2);
            do_reset(); load_all(); walk(p == 1 ? 5 : 0);
        end
        // zero polynomials: every input is a solution
        set_poly(0); do_reset(); load_all(); walk(0);
        // constant one: no input is a solution
        set_poly(1); do_reset(); load_all(); walk(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule